// File: doc/BRIEF.md
# Two-Wire Tuning Word Receiver

This block is a write-only slave on a two-wire serial bus, with open-drain data. It sits beside a digitally tuned capacitor and holds the two control values the capacitor core reads. The first value is a 5-bit tuning step. The second is a flag that puts the core into low-current standby. A bus master sends one fixed frame of 18 SCL clocks:

- a 7-bit device address and a direction bit;
- an acknowledge from this block;
- one data byte;
- a second acknowledge.

The new values take effect on the rising SCL edge of that last acknowledge, not at the STOP condition. Two such receivers can share one bus. A strap input moves the address of each one by one.

The block samples SCL and SDA with its own much faster system clock. Each line passes through a two-flop synchronizer, and edges are found in the system-clock domain. The system clock must run at least 8 times faster than SCL, and SCL runs at no more than 400 kHz. The block never drives SDA high. It only asserts a pull-down enable for an external open-drain driver.

Top module: `tune_ctl_rx`

## Requirements
- R1: After reset the tuning output is 00000, the standby output is 0 and the SDA pull-down is off.
- R2: A falling SDA while SCL is high (START) begins a new frame from its first bit, even in the middle of an earlier frame (repeated START).
- R3: Bits are taken on rising SCL edges, most significant first. The first 7 bits are the address and the 8th is the direction bit. The frame is accepted only when the address equals 1110000 with `addr_sel` low, or 1110001 with `addr_sel` high, and the direction bit is 0.
- R4: For an accepted address, the pull-down turns on at the SCL fall after the 8th clock and turns off at the SCL fall after the 9th clock.
- R5: The data byte arrives most significant bit first. Bit 5 is the standby flag (1 = standby, 0 = active), bits 4..0 are the tuning step, and bits 7..6 are ignored.
- R6: In an accepted frame, the pull-down is also on from the SCL fall after the 17th clock to the SCL fall after the 18th clock.
- R7: Both outputs keep their old values through the data byte. They take the new values on the rising SCL edge of the 18th clock.
- R8: When the address does not match, or the direction bit is 1, the pull-down stays off for the rest of the frame and the outputs do not change.
- R9: A STOP (SDA rising while SCL is high) or a repeated START before the 18th clock discards the partial frame, and the outputs keep their values.
- R10: An SDA change that falls in the same system cycle as an SCL fall is not taken as a START or a STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_sel | input | 1 | Address strap, forms the address LSB |
| scl_in | input | 1 | Serial clock from the bus |
| sda_in | input | 1 | Serial data as seen on the bus |
| sda_pull | output | 1 | Enable for the open-drain SDA pull-down |
| tune_state | output | 5 | Applied tuning step |
| standby | output | 1 | Applied standby flag, 1 = standby |

## Verification
START and STOP detection both look at SCL being high at an SDA transition. An SCL fall and an SDA change can land in the same synchronized system cycle, which is a hazard for that logic. The bench provokes this by running whole frames in which it toggles SDA at the same instant it lowers SCL after every bit. This produces both a falling and a rising SDA in the same cycle as the SCL fall. A false START or STOP would discard the frame, so the frame is judged by whether its tuning step and standby flag are still applied as the model predicts.

// File: rtl/tune_pkg.sv
package tune_pkg;

  localparam int TUNE_ADDR_W  = 7;
  localparam int TUNE_DATA_W  = 8;
  localparam int TUNE_STATE_W = 5;
  localparam logic [TUNE_ADDR_W-1:0] TUNE_ADDR_BASE = 7'b1110000;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ACK_A,
    ST_DATA,
    ST_ACK_D,
    ST_SKIP
  } rx_state_t;

endpackage

// File: rtl/tune_sync.sv
module tune_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_rise,
  output logic scl_fall,
  output logic sda_bit,
  output logic start_det,
  output logic stop_det
);

  localparam int LINES = 2;

  logic [LINES-1:0] pin_raw;
  logic [LINES-1:0] pin_now;
  logic [LINES-1:0] pin_prev;

  assign pin_raw = {sda_in, scl_in};

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [STAGES-1:0] chain_q;
    logic [STAGES-1:0] chain_d;
    logic              prev_q;

    assign chain_d = {chain_q[STAGES-2:0], pin_raw[g]};

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        chain_q <= '1;
        prev_q  <= 1'b1;
      end else begin
        chain_q <= chain_d;
        prev_q  <= chain_q[STAGES-1];
      end
    end

    assign pin_now[g]  = chain_q[STAGES-1];
    assign pin_prev[g] = prev_q;
  end

  // index 0 is SCL, index 1 is SDA
  assign scl_rise  =  pin_now[0] & ~pin_prev[0];
  assign scl_fall  = ~pin_now[0] &  pin_prev[0];
  assign sda_bit   =  pin_now[1];
  // both SCL samples must be high so an SDA move coinciding with an SCL fall is ignored
  assign start_det =  pin_now[0] & pin_prev[0] &  pin_prev[1] & ~pin_now[1];
  assign stop_det  =  pin_now[0] & pin_prev[0] & ~pin_prev[1] &  pin_now[1];

endmodule

// File: rtl/tune_frame.sv
module tune_frame
  import tune_pkg::*;
#(
  parameter int ADDR_W  = TUNE_ADDR_W,
  parameter int DATA_W  = TUNE_DATA_W,
  parameter int STATE_W = TUNE_STATE_W,
  parameter logic [ADDR_W-1:0] ADDR_BASE = TUNE_ADDR_BASE
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             addr_sel,
  input  logic             scl_rise,
  input  logic             scl_fall,
  input  logic             sda_bit,
  input  logic             start_det,
  input  logic             stop_det,
  output logic             sda_pull,
  output logic             apply_stb,
  output logic [STATE_W:0] payload,
  output rx_state_t        st_o
);

  localparam int CNT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DATA_W - 1);

  rx_state_t           st_q, st_n;
  logic [CNT_W-1:0]    cnt_q, cnt_n;
  logic [DATA_W-2:0]   sh_q, sh_n;
  logic [STATE_W:0]    pay_q, pay_n;
  logic                pull_q, pull_n;
  logic                slot_q, slot_n;
  logic                apply_q, apply_n;
  logic [DATA_W-1:0]   word_n;
  logic [ADDR_W-1:0]   my_addr;

  assign my_addr = {ADDR_BASE[ADDR_W-1:1], addr_sel};
  assign word_n  = {sh_q, sda_bit};

  always_comb begin
    st_n    = st_q;
    cnt_n   = cnt_q;
    sh_n    = sh_q;
    pay_n   = pay_q;
    pull_n  = pull_q;
    slot_n  = slot_q;
    apply_n = 1'b0;
    if (start_det) begin
      st_n   = ST_ADDR;
      cnt_n  = '0;
      pull_n = 1'b0;
      slot_n = 1'b0;
    end else if (stop_det) begin
      st_n   = ST_IDLE;
      pull_n = 1'b0;
      slot_n = 1'b0;
    end else begin
      unique case (st_q)
        ST_ADDR, ST_DATA: begin
          if (scl_rise) begin
            sh_n = word_n[DATA_W-2:0];
            if (cnt_q == CNT_LAST) begin
              cnt_n = '0;
              if (st_q == ST_DATA) begin
                pay_n = word_n[STATE_W:0];
                st_n  = ST_ACK_D;
              end else if (word_n == {my_addr, 1'b0}) begin
                st_n = ST_ACK_A;
              end else begin
                st_n = ST_SKIP;
              end
            end else begin
              cnt_n = cnt_q + 1'b1;
            end
          end
        end
        ST_ACK_A, ST_ACK_D: begin
          if (scl_fall) begin
            if (slot_q) begin
              pull_n = 1'b0;
              slot_n = 1'b0;
              st_n   = (st_q == ST_ACK_A) ? ST_DATA : ST_IDLE;
            end else begin
              pull_n = 1'b1;
            end
          end else if (scl_rise && pull_q) begin
            slot_n  = 1'b1;
            apply_n = (st_q == ST_ACK_D);
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      cnt_q   <= '0;
      sh_q    <= '0;
      pay_q   <= '0;
      pull_q  <= 1'b0;
      slot_q  <= 1'b0;
      apply_q <= 1'b0;
    end else begin
      st_q    <= st_n;
      cnt_q   <= cnt_n;
      sh_q    <= sh_n;
      pay_q   <= pay_n;
      pull_q  <= pull_n;
      slot_q  <= slot_n;
      apply_q <= apply_n;
    end
  end

  assign sda_pull  = pull_q;
  assign apply_stb = apply_q;
  assign payload   = pay_q;
  assign st_o      = st_q;

endmodule

// File: rtl/tune_out_reg.sv
module tune_out_reg #(
  parameter int STATE_W = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               apply_stb,
  input  logic [STATE_W:0]   payload,
  output logic [STATE_W-1:0] tune_state,
  output logic               standby
);

  logic [STATE_W-1:0] state_q, state_n;
  logic               stby_q, stby_n;

  always_comb begin
    state_n = state_q;
    stby_n  = stby_q;
    if (apply_stb) begin
      state_n = payload[STATE_W-1:0];
      stby_n  = payload[STATE_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= '0;
      stby_q  <= 1'b0;
    end else begin
      state_q <= state_n;
      stby_q  <= stby_n;
    end
  end

  assign tune_state = state_q;
  assign standby    = stby_q;

endmodule

// File: rtl/tune_ctl_rx.sv
module tune_ctl_rx
  import tune_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W      = TUNE_ADDR_W,
  parameter int DATA_W      = TUNE_DATA_W,
  parameter int STATE_W     = TUNE_STATE_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               addr_sel,
  input  logic               scl_in,
  input  logic               sda_in,
  output logic               sda_pull,
  output logic [STATE_W-1:0] tune_state,
  output logic               standby
);

  logic [1:0]       rst_pipe;
  logic             rst_i;
  logic             scl_rise, scl_fall, sda_bit, start_det, stop_det;
  logic             apply_stb;
  logic [STATE_W:0] payload;
  rx_state_t        fsm_st;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_i = rst_pipe[1];

  tune_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk       (clk),
    .rst_n     (rst_i),
    .scl_in    (scl_in),
    .sda_in    (sda_in),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .sda_bit   (sda_bit),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  tune_frame #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .STATE_W (STATE_W)
  ) i_frame (
    .clk       (clk),
    .rst_n     (rst_i),
    .addr_sel  (addr_sel),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .sda_bit   (sda_bit),
    .start_det (start_det),
    .stop_det  (stop_det),
    .sda_pull  (sda_pull),
    .apply_stb (apply_stb),
    .payload   (payload),
    .st_o      (fsm_st)
  );

  tune_out_reg #(.STATE_W(STATE_W)) i_out (
    .clk        (clk),
    .rst_n      (rst_i),
    .apply_stb  (apply_stb),
    .payload    (payload),
    .tune_state (tune_state),
    .standby    (standby)
  );

endmodule

// File: rtl/tune_ctl_rx_chk.sv
module tune_ctl_rx_chk
  import tune_pkg::*;
#(
  parameter int STATE_W = TUNE_STATE_W
) (
  input logic               clk,
  input logic               rst_n,
  input logic               sda_pull,
  input logic [STATE_W-1:0] tune_state,
  input logic               standby,
  input logic               apply_stb,
  input rx_state_t          fsm_st,
  input logic               start_det,
  input logic               stop_det,
  input logic               scl_fall
);

  AST_OUT_ON_APPLY: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({tune_state, standby}) |-> $past(apply_stb)); // R7

  AST_PULL_IN_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    sda_pull |-> (fsm_st == ST_ACK_A || fsm_st == ST_ACK_D)); // R4

  AST_SKIP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (fsm_st == ST_SKIP) |-> !sda_pull); // R8

  AST_STOP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (fsm_st == ST_IDLE)); // R9

  AST_START_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> (fsm_st == ST_ADDR)); // R2

  AST_PULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sda_pull) |-> $past(scl_fall || start_det || stop_det)); // R6

endmodule

bind tune_ctl_rx tune_ctl_rx_chk #(.STATE_W(STATE_W)) i_chk (
  .clk        (clk),
  .rst_n      (rst_i),
  .sda_pull   (sda_pull),
  .tune_state (tune_state),
  .standby    (standby),
  .apply_stb  (apply_stb),
  .fsm_st     (fsm_st),
  .start_det  (start_det),
  .stop_det   (stop_det),
  .scl_fall   (scl_fall)
);

// File: tb/test_tune_ctl_rx.sv
module test_tune_ctl_rx;

  localparam int CLK_NS = 10;
  localparam int QTR    = 10;

  logic       clk = 1'b0;
  logic       rst_n, addr_sel, scl_drv, sda_drv;
  logic       sda_line;
  logic       sda_pull;
  logic [4:0] tune_state;
  logic       standby;

  typedef struct {
    int    st;
    int    sb;
    string tag;
  } exp_t;

  exp_t  expq[$];
  int    n_chk = 0;
  int    n_bad = 0;
  bit    done  = 0;
  event  frame_done;
  int    m_state, m_stby;
  bit    pull_lo, pull_hi;
  int    obs_st, obs_sb;

  always #(CLK_NS/2) clk = ~clk;

  assign sda_line = sda_drv & ~sda_pull;

  tune_ctl_rx i_tune_ctl_rx (
    .clk        (clk),
    .rst_n      (rst_n),
    .addr_sel   (addr_sel),
    .scl_in     (scl_drv),
    .sda_in     (sda_line),
    .sda_pull   (sda_pull),
    .tune_state (tune_state),
    .standby    (standby)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic qwait();
    repeat (QTR) @(negedge clk);
  endtask

  task automatic send_bit(input bit b, input bit same);
    sda_drv = b;
    qwait();
    pull_lo = sda_pull;
    scl_drv = 1'b1;
    qwait();
    pull_hi = sda_pull;
    obs_st  = tune_state;
    obs_sb  = standby;
    qwait();
    scl_drv = 1'b0;
    if (same) sda_drv = ~b;
    qwait();
  endtask

  task automatic bus_start();
    sda_drv = 1'b1; qwait();
    scl_drv = 1'b1; qwait();
    sda_drv = 1'b0; qwait();
    scl_drv = 1'b0; qwait();
  endtask

  task automatic bus_stop();
    sda_drv = 1'b0; qwait();
    scl_drv = 1'b1; qwait();
    sda_drv = 1'b1; qwait();
  endtask

  // driver: sends one frame, checks the acknowledge windows, queues the expected outputs
  task automatic send_frame(input bit [6:0] a, input bit rw, input bit [7:0] d,
                            input int abort_at, input bit restart, input bit same,
                            input string tag);
    bit [15:0] bits;
    bit        match;
    bit        aborted;
    int        old_st, old_sb;
    string     rq;
    exp_t      e;
    bits    = {a, rw, d};
    match   = (a == {6'b111000, addr_sel}) && !rw;
    aborted = 1'b0;
    old_st  = m_state;
    old_sb  = m_stby;
    bus_start();
    for (int n = 0; n < 16; n++) begin
      send_bit(bits[15-n], same);
      if (n + 1 == abort_at) begin
        aborted = 1'b1;
        if (!restart) bus_stop();
        break;
      end
      if (n == 15 && match) begin
        check(obs_st == old_st, "R7 state held during last data bit", obs_st, old_st);
        check(obs_sb == old_sb, "R7 standby held during last data bit", obs_sb, old_sb);
      end
      if (n == 7 || n == 15) begin
        send_bit(1'b1, 1'b0);
        rq = !match ? "R8 no pull-down" : (n == 7) ? "R4 address ack" : "R6 data ack";
        check(pull_lo == match, {rq, " before ack clock"}, pull_lo, match);
        check(pull_hi == match, {rq, " during ack clock"}, pull_hi, match);
        if (n == 15 && match) begin
          check(obs_st == d[4:0], "R7 state applied at ack edge", obs_st, d[4:0]);
          check(obs_sb == d[5], "R7 standby applied at ack edge", obs_sb, d[5]);
        end
      end
    end
    if (!aborted) begin
      bus_stop();
      check(sda_pull == 1'b0, "R4 pull-down released after ack", sda_pull, 0);
      if (match) begin
        m_state = d[4:0];
        m_stby  = d[5];
      end
    end
    e.st  = m_state;
    e.sb  = m_stby;
    e.tag = tag;
    expq.push_back(e);
    -> frame_done;
    qwait();
  endtask

  // monitor: compares the applied outputs against the queued expectations
  initial begin
    forever begin
      @(frame_done);
      while (expq.size() > 0) begin
        exp_t e;
        e = expq.pop_front();
        check(tune_state == e.st[4:0], {e.tag, " tuning state"}, tune_state, e.st);
        check(standby == e.sb[0], {e.tag, " standby"}, standby, e.sb);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n    = 1'b0;
    addr_sel = 1'b0;
    scl_drv  = 1'b1;
    sda_drv  = 1'b1;
    m_state  = 0;
    m_stby   = 0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    check(tune_state == 5'd0, "R1 reset tuning state", tune_state, 0);
    check(standby == 1'b0, "R1 reset standby", standby, 0);
    check(sda_pull == 1'b0, "R1 reset pull-down", sda_pull, 0);

    send_frame(7'h70, 1'b0, 8'h15, 0, 1'b0, 1'b0, "R3 R5 addr 0x70 data 0x15");
    send_frame(7'h70, 1'b0, 8'h2A, 0, 1'b0, 1'b1, "R10 R5 same-cycle edges data 0x2A");
    addr_sel = 1'b1;
    send_frame(7'h71, 1'b0, 8'hDF, 0, 1'b0, 1'b0, "R5 upper bits ignored data 0xDF");
    send_frame(7'h70, 1'b0, 8'h01, 0, 1'b0, 1'b0, "R8 address mismatch");
    send_frame(7'h71, 1'b1, 8'h02, 0, 1'b0, 1'b0, "R8 read direction");
    send_frame(7'h71, 1'b0, 8'h03, 12, 1'b0, 1'b0, "R9 stop mid data");
    send_frame(7'h71, 1'b0, 8'h07, 5, 1'b1, 1'b0, "R9 restart mid address");
    send_frame(7'h71, 1'b0, 8'h24, 0, 1'b0, 1'b0, "R2 frame after repeated start");
    send_frame(7'h71, 1'b0, 8'h00, 0, 1'b0, 1'b1, "R10 same-cycle edges data 0x00");

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule